// File: doc/BRIEF.md
# GPIO Pin Control Register Bank

This block is a byte-addressed register bank that governs a row of general-purpose pins. Each pin is selected by a byte index inside a register group plus a bit position 0 to 7 inside that byte, so byte index `i` bit `b` is pin `8*i+b`. For every pin the bank keeps a GPIO-ownership bit, a drive-enable (direction) bit, an output level bit, a pull-enable bit and a pull-polarity bit, and it presents a read-only view of the synchronized pad level.

A pin whose ownership bit is 0 is left to an alternate function: its pad output and pad drive-enable come straight from the alternate-function inputs. A pin whose ownership bit is 1 is driven from the output and direction registers. Pull requests to the pad are decoded from the two pull registers for every pin regardless of ownership. Software reaches the bank through a single synchronous byte port with a one-cycle read latency.

Top module: `gpio_pin_bank`

## Requirements
- R1: After reset every writable register reads 0, so every pin follows its alternate-function inputs and has neither pull-up nor pull-down requested.
- R2: Group base offsets are: pad level 0x000, GPIO ownership 0x040, direction 0x080, output level 0x0C0, pull enable 0x480, pull polarity 0x4C0; byte `base+i` (i below PINS/8) holds pins 8*i to 8*i+7 with pin 8*i+b in bit b, and a written byte reads back unchanged.
- R3: For a pin with ownership bit 1, `pad_oe` equals its direction bit (1 = output, 0 = input) and `pad_out` equals its output-level bit, one cycle after the write.
- R4: For a pin with ownership bit 0, `pad_out` equals `alt_out` and `pad_oe` equals `alt_oe` for that pin, combinationally.
- R5: With pull enable 1, pull polarity 1 asserts `pad_pu` and polarity 0 asserts `pad_pd`; with pull enable 0 neither is asserted, and the two are never asserted together on a pin.
- R6: Pad levels pass through two flops: a `pad_in` change sampled at clock edge k is returned by a pad-level read issued at edge k+2 or later, but not by one issued at edge k+1.
- R7: Writes to the pad-level group or to addresses outside all groups change no register, and reads of addresses outside all groups return 0.
- R8: Read data appears on `bus_rdata` in the cycle after the read request and is 0 in any cycle that follows no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the request |
| pad_in | input | PINS | Pad levels (asynchronous) |
| pad_out | output | PINS | Pad output level |
| pad_oe | output | PINS | Pad drive enable |
| pad_pu | output | PINS | Pull-up request |
| pad_pd | output | PINS | Pull-down request |
| alt_out | input | PINS | Alternate-function output level |
| alt_oe | input | PINS | Alternate-function drive enable |

## Verification
Every cycle the assertions check that no pin requests both pulls, that the pad-level path lags `pad_in` by exactly two edges, that ignored writes leave all configuration state unchanged, and that read data is zero after idle cycles and unmapped reads. The mix of ownership, direction and alternate-function values on the pad outputs, the bit placement of each pin inside its byte, read-back of every group and the boundary between the last mapped byte and the first unmapped one are shown only by the bench scenarios, which compare pad outputs and a scoreboard of expected read bytes against a model built from the requirements.

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank #(
  parameter int PINS     = 32,
  parameter int ADDR_W   = 12,
  parameter int BASE_IN  = 'h000,
  parameter int BASE_EN  = 'h040,
  parameter int BASE_DIR = 'h080,
  parameter int BASE_OUT = 'h0C0,
  parameter int BASE_PEN = 'h480,
  parameter int BASE_PUP = 'h4C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   pad_pu,
  output logic [PINS-1:0]   pad_pd,
  input  logic [PINS-1:0]   alt_out,
  input  logic [PINS-1:0]   alt_oe
);
  localparam int NB = PINS / 8;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  logic [PINS-1:0] en_q, dir_q, out_q, pen_q, pup_q, meta_q, in_sync;
  logic [IW+2:0]   lo;
  logic            hit_in, hit_en, hit_dir, hit_out, hit_pen, hit_pup, wr_hit, rd_hit;
  logic [7:0]      rd_mux;

  function automatic logic in_group(input logic [ADDR_W-1:0] a, input int base);
    return (int'(a) >= base) && (int'(a) < base + NB);
  endfunction

  assign hit_in  = in_group(bus_addr, BASE_IN);
  assign hit_en  = in_group(bus_addr, BASE_EN);
  assign hit_dir = in_group(bus_addr, BASE_DIR);
  assign hit_out = in_group(bus_addr, BASE_OUT);
  assign hit_pen = in_group(bus_addr, BASE_PEN);
  assign hit_pup = in_group(bus_addr, BASE_PUP);
  assign wr_hit  = hit_en | hit_dir | hit_out | hit_pen | hit_pup;
  assign rd_hit  = wr_hit | hit_in;
  assign lo      = {bus_addr[IW-1:0], 3'b000};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta_q  <= '0;
      in_sync <= '0;
    end else begin
      meta_q  <= pad_in;
      in_sync <= meta_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q  <= '0;
      dir_q <= '0;
      out_q <= '0;
      pen_q <= '0;
      pup_q <= '0;
    end else if (bus_sel && bus_wr) begin
      if (hit_en)  en_q[lo +: 8]  <= bus_wdata;
      if (hit_dir) dir_q[lo +: 8] <= bus_wdata;
      if (hit_out) out_q[lo +: 8] <= bus_wdata;
      if (hit_pen) pen_q[lo +: 8] <= bus_wdata;
      if (hit_pup) pup_q[lo +: 8] <= bus_wdata;
    end

  always_comb begin
    rd_mux = '0;
    if (hit_in)       rd_mux = in_sync[lo +: 8];
    else if (hit_en)  rd_mux = en_q[lo +: 8];
    else if (hit_dir) rd_mux = dir_q[lo +: 8];
    else if (hit_out) rd_mux = out_q[lo +: 8];
    else if (hit_pen) rd_mux = pen_q[lo +: 8];
    else if (hit_pup) rd_mux = pup_q[lo +: 8];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= (bus_sel && !bus_wr) ? rd_mux : 8'h00;

  assign pad_out = (en_q & out_q) | (~en_q & alt_out);
  assign pad_oe  = (en_q & dir_q) | (~en_q & alt_oe);
  assign pad_pu  = pen_q & pup_q;
  assign pad_pd  = pen_q & ~pup_q;

  AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_pd) == '0); // R5
  AST_SYNC_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2)) |-> in_sync == $past(pad_in, 2)); // R6
  AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !wr_hit) |=> $stable({en_q, dir_q, out_q, pen_q, pup_q})); // R7
  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !rd_hit) |=> bus_rdata == 8'h00); // R7
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> bus_rdata == 8'h00); // R8
endmodule

// File: tb/gpio_pin_bank_bench.sv
module gpio_pin_bank_bench;
  localparam int PINS = 32;
  localparam int NB   = PINS / 8;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic [PINS-1:0] pad_in = '0, pad_out, pad_oe, pad_pu, pad_pd;
  logic [PINS-1:0] alt_out = '0, alt_oe = '0;
  logic [PINS-1:0] m_en = '0, m_dir = '0, m_out = '0, m_pen = '0, m_pup = '0;

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  gpio_pin_bank #(.PINS(PINS), .ADDR_W(12)) u_gpio_pin_bank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .alt_out(alt_out), .alt_oe(alt_oe));

  task automatic check(input string tag, input logic [PINS-1:0] act, input logic [PINS-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk)
    if (rst_n && bus_sel && !bus_wr) begin
      #2;
      if (exp_q.size() == 0) check("R8 unexpected read", 1, 0);
      else check(tag_q.pop_front(), {24'h0, bus_rdata}, {24'h0, exp_q.pop_front()});
    end

  function automatic bit in_rng(input int a, input int b);
    return a >= b && a < b + NB;
  endfunction

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 12'(a); bus_wdata = d;
    if (in_rng(a, 'h040)) m_en [(a - 'h040)*8 +: 8] = d;
    if (in_rng(a, 'h080)) m_dir[(a - 'h080)*8 +: 8] = d;
    if (in_rng(a, 'h0C0)) m_out[(a - 'h0C0)*8 +: 8] = d;
    if (in_rng(a, 'h480)) m_pen[(a - 'h480)*8 +: 8] = d;
    if (in_rng(a, 'h4C0)) m_pup[(a - 'h4C0)*8 +: 8] = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_issue(input int a, input logic [7:0] e, input string tag);
    bus_sel = 1; bus_wr = 0; bus_addr = 12'(a);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic rd(input int a, input logic [7:0] e, input string tag);
    @(negedge clk);
    rd_issue(a, e, tag);
  endtask

  task automatic chk_pads(input string tag);
    check({tag, " pad_out"}, pad_out, (m_en & m_out) | (~m_en & alt_out));
    check({tag, " pad_oe"},  pad_oe,  (m_en & m_dir) | (~m_en & alt_oe));
    check({tag, " pad_pu"},  pad_pu,  m_pen & m_pup);
    check({tag, " pad_pd"},  pad_pd,  m_pen & ~m_pup);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog expired", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset pad_oe", pad_oe, '0);
    check("R1 reset pad_out", pad_out, '0);
    check("R1 reset pulls", pad_pu | pad_pd, '0);
    rd('h040, 8'h00, "R1 reset ownership byte0");
    rd('h083, 8'h00, "R1 reset direction byte3");
    rd('h480, 8'h00, "R1 reset pull enable byte0");

    alt_out = 32'hA5A5_0F0F; alt_oe = 32'hFFFF_0000;
    #1 chk_pads("R4 alternate passthrough");

    wr('h041, 8'hFF); wr('h081, 8'h0F); wr('h0C1, 8'h33);
    chk_pads("R3 gpio byte1");
    rd('h041, 8'hFF, "R2 readback ownership byte1");
    rd('h081, 8'h0F, "R2 readback direction byte1");
    rd('h0C1, 8'h33, "R2 readback output byte1");
    wr('h043, 8'h80); wr('h083, 8'h80); wr('h0C3, 8'h80);
    check("R2 pin31 bit7 pad_out", {31'h0, pad_out[31]}, 1);
    check("R2 pin31 bit7 pad_oe", {31'h0, pad_oe[31]}, 1);
    chk_pads("R3 pin31");
    alt_out = ~alt_out; alt_oe = 32'h0000_FFFF;
    #1 chk_pads("R4 alternate change with mixed ownership");
    wr('h081, 8'hF0);
    chk_pads("R3 direction flip byte1");

    wr('h480, 8'h0F); wr('h4C0, 8'h05); wr('h4C1, 8'hFF);
    chk_pads("R5 pull mix");
    check("R5 pull-up pins0/2", pad_pu[7:0], 8'h05);
    check("R5 pull-down pins1/3", pad_pd[7:0], 8'h0A);
    rd('h4C1, 8'hFF, "R2 readback pull polarity byte1");

    @(negedge clk);
    pad_in = 32'h1234_5678;
    @(negedge clk);
    rd_issue('h000, 8'h00, "R6 one edge not yet visible");
    rd_issue('h000, 8'h78, "R6 two edges visible byte0");
    rd('h003, 8'h12, "R6 byte3");

    wr('h000, 8'hFF);
    wr('h044, 8'hFF);
    wr('h100, 8'hFF);
    wr('h4C4, 8'hFF);
    chk_pads("R7 ignored writes");
    rd('h000, 8'h78, "R7 pad-level group not writable");
    rd('h044, 8'h00, "R7 first unmapped byte reads 0");
    rd('h7FF, 8'h00, "R7 far unmapped reads 0");
    rd('h043, 8'h80, "R7 last mapped byte kept");

    @(negedge clk);
    @(negedge clk);
    check("R8 idle rdata zero", {24'h0, bus_rdata}, 0);

    rst_n = 0;
    m_en = '0; m_dir = '0; m_out = '0; m_pen = '0; m_pup = '0;
    #1 chk_pads("R1 mid-run reset");
    @(negedge clk);
    rst_n = 1;
    rd('h0C3, 8'h00, "R1 output cleared by reset");

    repeat (3) @(negedge clk);
    check("R8 scoreboard drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule